// File: doc/BRIEF.md
# Conversion Rate and Mode Sequencer

This block sets the result timing of a sigma-delta converter front end. It counts master clock ticks to decide when a new conversion result is due. When a result is due, it copies a 16-bit sample from an input port into a data register and pulls an active-low ready flag low. The modulator and filter arithmetic sit outside the block. The sample port stands in for the finished filter output.

Three settings control the timing. The operating-mode field selects continuous conversion, one single conversion that then falls asleep, or power-down. The rate select picks one of eight update rates. The clock-divide select stretches the update period for low-power operation. Any write to the mode or the rate/divide settings restarts the conversion. After a restart, the filter needs two full update periods to settle before the first result appears. A host reads the data register while the ready flag is low and reports the end of each read with a pulse. The ready flag rises one cycle before every register update, so a read never overlaps a change of the register.

Top module: `conv_seq_top`

## Requirements
- R1: After reset, mode_o is 00 (continuous), rate_o is 3'b100, div_o is 2'b00, data_o is 0x0000 and rdy_n is 1.
- R2: Mode codes: 00 is continuous conversion and 10 is single conversion. 11 is power-down, and the reserved code 01 acts exactly like power-down.
- R3: The update period P, in master clock cycles, is floor(CLK_HZ*10 / D) shifted left by div_o. D is the rate in tenths of a hertz: rate codes 0 through 7 give D = 1200, 1000, 333, 200, 166, 167, 133 and 95.
- R4: A restart is a reset, a mode_wr or a cfg_wr. After a restart, the first update comes on the 2P+1-th rising edge, counting the restart edge as the first. In continuous mode, later updates follow every P edges.
- R5: On each update edge, data_o takes the value on sample_in and rdy_n goes to 0. If rdy_n is low, it goes to 1 on the edge one cycle before the update.
- R6: An rd_done pulse sets rdy_n to 1 on the next edge, unless that edge is an update edge.
- R7: In single mode, exactly one result is produced after the 2P settling time. On that same update edge, mode_o becomes 11.
- R8: In power-down and in the reserved mode, data_o and rdy_n do not change except through rd_done. A mode or cfg write sets rdy_n to 1.
- R9: After each update, data_o equals the sample_in value present before the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load mode_in into the mode register and restart |
| mode_in | input | 2 | New operating mode |
| cfg_wr | input | 1 | Load rate_in and div_in and restart |
| rate_in | input | 3 | New update-rate select |
| div_in | input | 2 | New clock-divide exponent |
| sample_in | input | 16 | Sample captured at each update |
| rd_done | input | 1 | Pulse marking the end of a data read |
| mode_o | output | 2 | Current operating mode |
| rate_o | output | 3 | Current rate select |
| div_o | output | 2 | Current divide exponent |
| data_o | output | 16 | Data register |
| rdy_n | output | 1 | Active-low result-ready flag |

## Verification
The bench measures, to the exact edge, how long the first result takes after a restart and how far apart later results are. It does this for random rate and divide pairs, including the shortest and the longest period. An off-by-one counter, a missing settling period, or ignoring the divide shift would each move the ready edge and fail. The bench leaves one result unread to confirm the flag rises exactly one cycle before the next update. A design that changed the register while the flag was low would be caught there. The bench also checks three more cases: single conversion must fall into power-down holding its result, the reserved code must freeze the register, and a configuration write must drop a pending ready.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        MODE_CONT   = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_PDOWN  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] div;
        logic [2:0] rate;
    } cfg_t;

    localparam int unsigned RATE_CODES = 8;
    localparam logic [2:0]  RATE_RST   = 3'd4;
    localparam logic [1:0]  DIV_RST    = 2'd0;

    // update rate in tenths of a hertz
    function automatic int unsigned rate_dhz(input int unsigned code);
        case (code)
            0:       return 1200;
            1:       return 1000;
            2:       return 333;
            3:       return 200;
            4:       return 166;
            5:       return 167;
            6:       return 133;
            default: return 95;
        endcase
    endfunction

    function automatic longint unsigned base_ticks(input int unsigned code,
                                                   input longint unsigned clk_hz);
        return (clk_hz * 10) / longint'(rate_dhz(code));
    endfunction

    function automatic logic mode_runs(input mode_e m);
        return (m == MODE_CONT) || (m == MODE_SINGLE);
    endfunction

endpackage

// File: rtl/conv_seq_regs.sv
module conv_seq_regs
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [1:0] mode_in,
    input  logic       cfg_wr,
    input  logic [2:0] rate_in,
    input  logic [1:0] div_in,
    input  logic       single_done,
    output mode_e      mode,
    output cfg_t       cfg,
    output logic       restart
);

    assign restart = mode_wr | cfg_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_CONT;
            cfg  <= '{div: DIV_RST, rate: RATE_RST};
        end else begin
            if (mode_wr)
                mode <= mode_e'(mode_in);
            else if (single_done)
                mode <= MODE_PDOWN;
            if (cfg_wr)
                cfg <= '{div: div_in, rate: rate_in};
        end
    end

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg));

endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer
    import conv_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 4_915_200,
    parameter int unsigned     CNT_W  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    input  cfg_t cfg,
    output logic due_pre,
    output logic due_now
);

    logic [CNT_W-1:0] lut [RATE_CODES];
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;
    logic             settling;
    logic             wrap;

    generate
        for (genvar g = 0; g < RATE_CODES; g++) begin : g_lut
            assign lut[g] = CNT_W'(base_ticks(g, CLK_HZ));
        end
    endgenerate

    assign period  = lut[cfg.rate] << cfg.div;
    assign wrap    = (cnt == period - 1'b1);
    assign due_now = active & ~restart & ~settling & wrap;
    assign due_pre = active & ~restart & ~settling & (cnt == period - 2'd2);

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            cnt      <= '0;
            settling <= 1'b1;
        end else if (wrap) begin
            cnt      <= '0;
            settling <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_period_floor_r3: assert property (@(posedge clk) disable iff (rst)
        period >= 2);

    p_wrap_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (due_now && !restart) |=> (cnt == '0) && !settling);

endmodule

// File: rtl/conv_seq_out.sv
module conv_seq_out #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              due_pre,
    input  logic              due_now,
    input  logic              restart,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] data,
    output logic              rdy_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            rdy_n <= 1'b1;
        end else if (due_now) begin
            data  <= sample_in;
            rdy_n <= 1'b0;
        end else if (restart || due_pre || rd_done) begin
            rdy_n <= 1'b1;
        end
    end

    p_rd_release_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !due_now) |=> rdy_n);

endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
    import conv_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 4_915_200,
    parameter int unsigned     CNT_W  = 32,
    parameter int unsigned     DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_in,
    input  logic              cfg_wr,
    input  logic [2:0]        rate_in,
    input  logic [1:0]        div_in,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              rd_done,
    output logic [1:0]        mode_o,
    output logic [2:0]        rate_o,
    output logic [1:0]        div_o,
    output logic [DATA_W-1:0] data_o,
    output logic              rdy_n
);

    mode_e mode;
    cfg_t  cfg;
    logic  restart, due_pre, due_now, single_done;

    assign single_done = due_now & (mode == MODE_SINGLE);

    conv_seq_regs u_regs (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
        .cfg_wr(cfg_wr), .rate_in(rate_in), .div_in(div_in),
        .single_done(single_done), .mode(mode), .cfg(cfg), .restart(restart)
    );

    conv_seq_timer #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .active(mode_runs(mode)),
        .cfg(cfg), .due_pre(due_pre), .due_now(due_now)
    );

    conv_seq_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .due_pre(due_pre), .due_now(due_now),
        .restart(restart), .rd_done(rd_done), .sample_in(sample_in),
        .data(data_o), .rdy_n(rdy_n)
    );

    assign mode_o = mode;
    assign rate_o = cfg.rate;
    assign div_o  = cfg.div;

    // modes 01 and 11 both have bit 0 set: no update may follow
    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (rst)
        mode_o[0] |=> $stable(data_o));

    p_pre_release_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_o) |-> $past(rdy_n));

    p_single_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 2'b10 && $fell(rdy_n) && !$past(mode_wr)) |-> mode_o == 2'b11);

endmodule

// File: tb/conv_seq_top_bench.sv
module conv_seq_top_bench;

    localparam longint unsigned CLK_HZ = 1200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0, cfg_wr = 1'b0, rd_done = 1'b0;
    logic [1:0]  mode_in = '0, div_in = '0;
    logic [2:0]  rate_in = '0;
    logic [15:0] sample_in = '0;
    logic [1:0]  mode_o, div_o;
    logic [2:0]  rate_o;
    logic [15:0] data_o;
    logic        rdy_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    conv_seq_top #(.CLK_HZ(CLK_HZ)) u_conv_seq_top (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
        .cfg_wr(cfg_wr), .rate_in(rate_in), .div_in(div_in),
        .sample_in(sample_in), .rd_done(rd_done), .mode_o(mode_o),
        .rate_o(rate_o), .div_o(div_o), .data_o(data_o), .rdy_n(rdy_n)
    );

    function automatic int exp_period(input int r, input int d);
        int dhz;
        case (r)
            0: dhz = 1200; 1: dhz = 1000; 2: dhz = 333; 3: dhz = 200;
            4: dhz = 166;  5: dhz = 167;  6: dhz = 133; default: dhz = 95;
        endcase
        return (int'(CLK_HZ) * 10 / dhz) << d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall(input int start, output int n);
        n = start;
        while (rdy_n && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic write_cfg(input int r, input int d);
        @(negedge clk);
        rate_in = 3'(r); div_in = 2'(d); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic write_mode(input int m);
        @(negedge clk);
        mode_in = 2'(m); mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic read_pulse();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    // restart already applied, we sit one edge past it
    task automatic measure(input int r, input int d, input string tag);
        int n, p;
        logic [15:0] s;
        p = exp_period(r, d);
        wait_fall(1, n);
        check(n == 2 * p + 1, {tag, " R4 first result"}, n, 2 * p + 1);
        check(data_o == sample_in, {tag, " R9 data"}, data_o, sample_in);
        s = 16'($urandom);
        sample_in = s;
        read_pulse();
        check(rdy_n == 1'b1, {tag, " R6 read release"}, rdy_n, 1);
        wait_fall(1, n);
        check(n == p, {tag, " R3 period"}, n, p);
        check(data_o == s, {tag, " R9 next data"}, data_o, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, p, r, d;
        logic [15:0] held;
        void'($urandom(32'd2024));
        sample_in = 16'h5A3C;
        repeat (3) @(negedge clk);
        check(mode_o == 2'b00, "R1 mode", mode_o, 0);
        check(rate_o == 3'd4, "R1 rate", rate_o, 4);
        check(div_o == 2'd0, "R1 div", div_o, 0);
        check(data_o == 16'h0000, "R1 data", data_o, 0);
        check(rdy_n == 1'b1, "R1 ready", rdy_n, 1);
        rst = 1'b0;
        measure(4, 0, "reset default");

        // R5: leave unread, flag must rise one cycle ahead of the update
        p = exp_period(4, 0);
        held = data_o;
        sample_in = 16'hBEEF;
        n = 0;
        while (!rdy_n && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n == p - 1, "R5 early rise", n, p - 1);
        check(data_o == held, "R5 data unchanged while high", data_o, held);
        @(negedge clk);
        check(rdy_n == 1'b0 && data_o == 16'hBEEF, "R5 update after rise", data_o, 16'hBEEF);

        // R8: cfg write drops a pending ready
        write_cfg(0, 0);
        check(rdy_n == 1'b1, "R8 write releases ready", rdy_n, 1);
        measure(0, 0, "shortest");
        write_cfg(7, 3);
        measure(7, 3, "longest");

        for (int i = 0; i < 6; i++) begin
            r = int'($urandom % 8);
            d = int'($urandom % 4);
            sample_in = 16'($urandom);
            write_cfg(r, d);
            measure(r, d, "random");
        end

        // R7 single conversion
        write_cfg(1, 1);
        p = exp_period(1, 1);
        sample_in = 16'h1234;
        write_mode(2);
        wait_fall(1, n);
        check(n == 2 * p + 1, "R7 single settle", n, 2 * p + 1);
        check(mode_o == 2'b11, "R7 single to power-down", mode_o, 3);
        check(data_o == 16'h1234, "R7 single data", data_o, 16'h1234);
        sample_in = 16'h7777;
        repeat (3 * p) @(negedge clk);
        check(rdy_n == 1'b0, "R8 power-down keeps ready", rdy_n, 0);
        check(data_o == 16'h1234, "R8 power-down holds data", data_o, 16'h1234);
        read_pulse();
        check(rdy_n == 1'b1, "R6 read in power-down", rdy_n, 1);

        // R2 reserved code behaves as power-down
        write_mode(0);
        wait_fall(1, n);
        held = data_o;
        write_mode(1);
        check(rdy_n == 1'b1, "R8 mode write releases ready", rdy_n, 1);
        repeat (3 * p) @(negedge clk);
        check(rdy_n == 1'b1 && data_o == held, "R2 reserved acts as power-down", data_o, held);
        write_mode(3);
        repeat (3 * p) @(negedge clk);
        check(rdy_n == 1'b1 && data_o == held, "R2 power-down idle", data_o, held);
        sample_in = 16'hC0DE;
        write_mode(0);
        measure(1, 1, "R2 continuous resumes");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule